// File: doc/BRIEF.md
# Serial Command Slave for a Four-Channel Output Controller

This block is the serial control port of a multi-channel output controller. An external host drives chip select, serial clock and serial data. The block runs in a faster system clock domain and brings those three pins in through synchronizers. It shifts in one 8-bit word per frame. The high nibble of the word is a command and the low nibble is one data bit per channel. On the chip-select rising edge the word is decoded, but only if the frame held a whole, nonzero number of 8-clock groups. A decoded word can update the per-channel data bits and the combining operator (OR or AND), and it always emits a one-cycle clear pulse to the diagnosis flags.

The same frame also returns a word to the host. Which word is returned is chosen by the command of the previous valid frame. After a read-back command the next frame returns the input states. After an echo command the next frame returns the previous word unchanged, and this happens once only. In every other case the next frame returns the 2-bit-per-channel standard diagnosis. The shift register passes data through from input to output with an eight-clock delay, so several blocks can be chained on one chip select.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, `data_bits` is 0000, `and_mode` is 0 (OR operator), `sdo_oe` is 0, `diag_clr` is 0, and the first frame returns `diag_std`.
- R2: While `cs_n` is high, `sdo_oe` is 0 and activity on `sclk` and `sdi` changes neither the outputs nor the state.
- R3: On a `cs_n` fall, the response word is captured. The bits go out MSB first: the value on `sdo` after the k-th `sclk` rise is response bit 8-k. `sdi` is sampled on `sclk` falls, MSB first.
- R4: A frame with zero clocks, or with a clock count that is not a multiple of 8, has no effect. It changes no data bit and no operator, gives no clear pulse, and leaves the next frame's response selection and echo word unchanged.
- R5: Command 0011 writes the data nibble to `data_bits` and selects OR (`and_mode`=0). Command 1111 writes the data nibble and selects AND (`and_mode`=1).
- R6: Every command other than 0000, 1100, 1010, 0011 and 1111 writes the data nibble and keeps the current operator.
- R7: Commands 0000, 1100 and 1010 leave `data_bits` and `and_mode` unchanged.
- R8: After command 1100, the next frame returns `{chan_in[3:0], diag_bit[3:0]}`, with channel 4 in the most significant position of each nibble.
- R9: After command 1010, the next frame returns the whole 8-bit word of that command. The frame after that returns `diag_std`, unless 1010 was sent again.
- R10: A bit that enters on `sdi` leaves on `sdo` eight clocks later. In a frame of 8N clocks, only the last 8 bits received are decoded.
- R11: Each valid frame produces exactly one `diag_clr` pulse, one system cycle wide, in the same cycle that any data or operator update takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, low at every `cs_n` transition |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out, MSB first |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver (0 = high impedance) |
| diag_std | input | 8 | Standard diagnosis, 2 bits per channel, channel 4 at the top |
| chan_in | input | 4 | Channel input states, bit 3 = channel 4 |
| diag_bit | input | 4 | 1-bit diagnosis per channel, bit 3 = channel 4 |
| data_bits | output | 4 | Per-channel data bits, bit 3 = channel 4 |
| and_mode | output | 1 | Combining operator: 0 = OR, 1 = AND |
| diag_clr | output | 1 | One-cycle pulse that clears the diagnosis flags |

## Verification
The hardest state to reach is the response-selection register. It cannot be observed directly: it only shows up in the word shifted out during the following frame. Its one-shot behaviour after an echo only shows after two more frames. The bench therefore sweeps all sixteen command codes in a row, twice, and predicts each returned word from a model of the previous frame. It places echo-then-diagnosis sequences and malformed frames (0, 7 and 12 clocks) between valid ones, so that any state a bad frame disturbs surfaces in the next response.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] OP_DIAG  = 4'b0000;
  localparam logic [CMD_W-1:0] OP_READ  = 4'b1100;
  localparam logic [CMD_W-1:0] OP_ECHO  = 4'b1010;
  localparam logic [CMD_W-1:0] OP_OR    = 4'b0011;
  localparam logic [CMD_W-1:0] OP_AND   = 4'b1111;

  typedef enum logic [1:0] {
    RSP_DIAG = 2'd0,
    RSP_READ = 2'd1,
    RSP_ECHO = 2'd2
  } rsp_sel_e;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int           W      = 3,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= INIT;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int FRAME = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_q,
  input  logic             sck_q,
  input  logic             sdi_q,
  input  logic [FRAME-1:0] load_word,
  output logic [FRAME-1:0] word,
  output logic             frame_ok,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int CNT_W = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME - 1);

  logic             cs_d, sck_d;
  logic             cs_fall, cs_rise, sck_rise, sck_fall, sel;
  logic [FRAME-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic             seen;

  assign sel      = ~cs_q;
  assign cs_fall  = cs_d & ~cs_q;
  assign cs_rise  = ~cs_d & cs_q;
  assign sck_rise = ~sck_d & sck_q;
  assign sck_fall = sck_d & ~sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d     <= 1'b1;
      sck_d    <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      seen     <= 1'b0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
      frame_ok <= 1'b0;
    end else begin
      cs_d     <= cs_q;
      sck_d    <= sck_q;
      frame_ok <= 1'b0;
      if (cs_fall) begin
        sh     <= load_word;
        cnt    <= '0;
        seen   <= 1'b0;
        sdo    <= load_word[FRAME-1];
        sdo_oe <= 1'b1;
      end else if (cs_rise) begin
        sdo_oe   <= 1'b0;
        frame_ok <= seen && (cnt == '0);
      end else if (sel) begin
        if (sck_fall) begin
          sh   <= {sh[FRAME-2:0], sdi_q};
          cnt  <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
          seen <= 1'b1;
        end
        if (sck_rise) sdo <= sh[FRAME-1];
      end
    end
  end

  assign word = sh;
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_cmd_pkg::*;
#(
  parameter int CHANNELS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_ok,
  input  logic [2*CHANNELS-1:0] word,
  input  logic [2*CHANNELS-1:0] diag_std,
  input  logic [CHANNELS-1:0]   chan_in,
  input  logic [CHANNELS-1:0]   diag_bit,
  output logic [2*CHANNELS-1:0] resp_word,
  output logic [CHANNELS-1:0]   data_bits,
  output logic                  and_mode,
  output logic                  diag_clr
);
  localparam int FRAME = 2 * CHANNELS;

  logic [CMD_W-1:0]    cmd;
  logic [CHANNELS-1:0] dat;
  logic [FRAME-1:0]    last_word;
  logic [FRAME-1:0]    read_word;
  rsp_sel_e            rsp_sel;

  assign cmd = word[FRAME-1 -: CMD_W];
  assign dat = word[CHANNELS-1:0];

  // channel n sits at bit n-1 of each half
  for (genvar g = 0; g < CHANNELS; g++) begin : g_read
    assign read_word[CHANNELS + g] = chan_in[g];
    assign read_word[g]            = diag_bit[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_bits <= '0;
      and_mode  <= 1'b0;
      diag_clr  <= 1'b0;
      last_word <= '0;
      rsp_sel   <= RSP_DIAG;
    end else begin
      diag_clr <= frame_ok;
      if (frame_ok) begin
        last_word <= word;
        rsp_sel   <= RSP_DIAG;
        case (cmd)
          OP_DIAG: ;
          OP_READ: rsp_sel <= RSP_READ;
          OP_ECHO: rsp_sel <= RSP_ECHO;
          OP_OR: begin
            and_mode  <= 1'b0;
            data_bits <= dat;
          end
          OP_AND: begin
            and_mode  <= 1'b1;
            data_bits <= dat;
          end
          default: data_bits <= dat;
        endcase
      end
    end
  end

  always_comb begin
    case (rsp_sel)
      RSP_READ: resp_word = read_word;
      RSP_ECHO: resp_word = last_word;
      default:  resp_word = diag_std;
    endcase
  end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int CHANNELS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdo_oe,
  input  logic [2*CHANNELS-1:0] diag_std,
  input  logic [CHANNELS-1:0]   chan_in,
  input  logic [CHANNELS-1:0]   diag_bit,
  output logic [CHANNELS-1:0]   data_bits,
  output logic                  and_mode,
  output logic                  diag_clr
);
  localparam int FRAME = 2 * CHANNELS;

  logic [2:0]       pins_q;
  logic [FRAME-1:0] word, resp_word;
  logic             frame_ok;

  spi_cmd_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q(pins_q)
  );

  spi_cmd_shifter #(.FRAME(FRAME)) u_shift (
    .clk(clk), .rst(rst),
    .cs_q(pins_q[2]), .sck_q(pins_q[1]), .sdi_q(pins_q[0]),
    .load_word(resp_word), .word(word), .frame_ok(frame_ok),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  spi_cmd_decode #(.CHANNELS(CHANNELS)) u_dec (
    .clk(clk), .rst(rst), .frame_ok(frame_ok), .word(word),
    .diag_std(diag_std), .chan_in(chan_in), .diag_bit(diag_bit),
    .resp_word(resp_word), .data_bits(data_bits),
    .and_mode(and_mode), .diag_clr(diag_clr)
  );
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
  parameter int CHANNELS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                cs_n,
  input logic                sdo_oe,
  input logic                diag_clr,
  input logic [CHANNELS-1:0] data_bits,
  input logic                and_mode
);
  AST_OE_OFF_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !sdo_oe) // R2
    else $error("sdo_oe high while deselected");

  AST_OE_RISES_AFTER_SELECT: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> !$past(cs_n, 2)) // R3
    else $error("sdo_oe rose without chip select");

  AST_CLR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    diag_clr |=> !diag_clr) // R11
    else $error("clear pulse wider than one cycle");

  AST_CLR_AFTER_DESELECT: assert property (@(posedge clk) disable iff (rst)
    diag_clr |-> !sdo_oe) // R11
    else $error("clear pulse while selected");

  AST_DATA_WITH_CLR: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_bits) |-> diag_clr) // R4
    else $error("data bits changed outside a valid frame");

  AST_MODE_WITH_CLR: assert property (@(posedge clk) disable iff (rst)
    !$stable(and_mode) |-> diag_clr) // R4
    else $error("operator changed outside a valid frame");
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sdo_oe(sdo_oe),
  .diag_clr(diag_clr), .data_bits(data_bits), .and_mode(and_mode)
);

// File: tb/spi_cmd_slave_test.sv
module spi_cmd_slave_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic       sdo, sdo_oe, and_mode, diag_clr;
  logic [7:0] diag_std = 8'hFF;
  logic [3:0] chan_in = 4'h0, diag_bit = 4'hF;
  logic [3:0] data_bits;

  int checks = 0, fails = 0, clr_cnt = 0;
  bit done = 0;

  // model state
  logic [3:0] m_data = 4'h0;
  logic       m_and = 1'b0;
  int         m_rsp = 0;     // 0 diag, 1 read-back, 2 echo
  logic [7:0] m_last = 8'h00;

  always #2 clk = ~clk;

  spi_cmd_slave uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .diag_std(diag_std), .chan_in(chan_in),
    .diag_bit(diag_bit), .data_bits(data_bits), .and_mode(and_mode),
    .diag_clr(diag_clr)
  );

  always @(posedge clk) if (!rst && diag_clr) clr_cnt++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] tx, input int n, output logic [15:0] rx);
    rx = '0;
    cs_n = 1'b0;
    wait_clk(8);
    for (int i = 0; i < n; i++) begin
      sdi = tx[n-1-i];
      sclk = 1'b1;
      wait_clk(8);
      rx[n-1-i] = sdo;
      sclk = 1'b0;
      wait_clk(8);
    end
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  function automatic logic [7:0] exp_resp();
    case (m_rsp)
      1: return {chan_in, diag_bit};
      2: return m_last;
      default: return diag_std;
    endcase
  endfunction

  function automatic void model_apply(input logic [7:0] w);
    m_last = w;
    m_rsp = 0;
    case (w[7:4])
      4'b0000: ;
      4'b1100: m_rsp = 1;
      4'b1010: m_rsp = 2;
      4'b0011: begin m_and = 1'b0; m_data = w[3:0]; end
      4'b1111: begin m_and = 1'b1; m_data = w[3:0]; end
      default: m_data = w[3:0];
    endcase
  endfunction

  // one valid 8-bit frame, checks response, data, operator and clear count
  task automatic cmd_frame(input logic [7:0] w, input string tag);
    logic [15:0] rx;
    logic [7:0]  er;
    int          c0;
    er = exp_resp();
    c0 = clr_cnt;
    frame({8'h00, w}, 8, rx);
    model_apply(w);
    check({tag, " response"}, rx, {8'h00, er});
    check(w[7:4] inside {4'b0000, 4'b1100, 4'b1010} ? "R7 data bits" :
          (w[7:4] inside {4'b0011, 4'b1111} ? "R5 data bits" : "R6 data bits"),
          {12'h0, data_bits}, {12'h0, m_data});
    check(w[7:4] inside {4'b0011, 4'b1111} ? "R5 operator" : "R6 operator",
          {15'h0, and_mode}, {15'h0, m_and});
    check("R11 one clear pulse", 16'(clr_cnt - c0), 16'd1);
  endtask

  initial begin
    logic [15:0] rx;
    logic [3:0]  prev_data;
    int          c0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    // R1 reset state
    check("R1 data bits", {12'h0, data_bits}, 16'h0000);
    check("R1 operator", {15'h0, and_mode}, 16'h0);
    check("R1 sdo_oe", {15'h0, sdo_oe}, 16'h0);
    check("R1 diag_clr", {15'h0, diag_clr}, 16'h0);

    // R2 activity while deselected is ignored
    c0 = clr_cnt;
    for (int i = 0; i < 12; i++) begin
      sdi = i[0]; sclk = 1'b1; wait_clk(6);
      check("R2 sdo_oe deselected", {15'h0, sdo_oe}, 16'h0);
      sclk = 1'b0; wait_clk(6);
    end
    check("R2 data bits unchanged", {12'h0, data_bits}, 16'h0);
    check("R2 no clear", 16'(clr_cnt - c0), 16'd0);

    // R1 / R3 first frame returns standard diagnosis
    diag_std = 8'hFF;
    cmd_frame(8'h35, "R1 R3");
    diag_std = 8'h1B;
    cmd_frame(8'hF6, "R3");

    // R4 malformed frames do nothing
    for (int k = 0; k < 3; k++) begin
      int nb;
      nb = (k == 0) ? 0 : ((k == 1) ? 7 : 12);
      c0 = clr_cnt;
      prev_data = data_bits;
      frame(16'hF0A5, nb, rx);
      check("R4 data bits kept", {12'h0, data_bits}, {12'h0, prev_data});
      check("R4 operator kept", {15'h0, and_mode}, {15'h0, m_and});
      check("R4 no clear", 16'(clr_cnt - c0), 16'd0);
    end
    diag_std = 8'h6C;
    cmd_frame(8'h00, "R4 selection kept");

    // sweep of every command code, twice
    for (int rep = 0; rep < 2; rep++) begin
      for (int c = 0; c < 16; c++) begin
        logic [7:0] w;
        string      tg;
        w = {4'(c), 4'((c * 7 + rep * 5 + 1) & 15)};
        diag_std = 8'((c * 37 + rep * 91 + 13) & 255);
        chan_in  = 4'((c * 3 + rep) & 15);
        diag_bit = 4'((c * 11 + 6) & 15);
        tg = (m_rsp == 1) ? "R8" : ((m_rsp == 2) ? "R9" : "R3");
        cmd_frame(w, tg);
      end
    end

    // R9 echo is one-shot, repeated echo echoes again
    diag_std = 8'hA3;
    cmd_frame(8'hA9, "R3");
    cmd_frame(8'h00, "R9 echo word");
    cmd_frame(8'h00, "R9 one-shot back to diagnosis");
    cmd_frame(8'hA4, "R9");
    cmd_frame(8'hA7, "R9 echo of first echo");
    cmd_frame(8'h00, "R9 echo of second echo");

    // R8 read-back with distinct inputs
    chan_in = 4'b1001; diag_bit = 4'b0110;
    cmd_frame(8'hC3, "R3");
    cmd_frame(8'h00, "R8 read-back word");

    // R10 chained 16-clock frame
    diag_std = 8'h5E;
    c0 = clr_cnt;
    frame(16'h3C_F2, 16, rx);
    check("R10 first byte is response", {8'h00, rx[15:8]}, {8'h00, exp_resp()});
    check("R10 pass-through after eight clocks", {8'h00, rx[7:0]}, 16'h003C);
    model_apply(8'hF2);
    check("R10 last byte decoded", {12'h0, data_bits}, {12'h0, m_data});
    check("R10 operator from last byte", {15'h0, and_mode}, {15'h0, m_and});
    check("R11 one clear for chained frame", 16'(clr_cnt - c0), 16'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule